// File: doc/BRIEF.md
# Cyclic Majority-Vote Decoder for the Length-7 Difference-Set Code

This block corrects hard-decision words of the length-7, dimension-3 cyclic code whose parity structure comes from the perfect difference set {0,2,3}. The code has minimum distance 4, so the block repairs any single bit error. A requester presents a 7-bit word together with a one-cycle start pulse. The block copies the word into a circular register. It then runs seven identical steps, one per clock.

In each step, three parity sums are formed over the register. All three include the top bit, and no other bit appears in more than one of them. When two or more of the sums are odd, the top bit is inverted in place. The register is then rotated left by one. Because the code is cyclic, this single set of sums decodes every position in turn. After the seventh step the word is back in its original alignment, and a one-cycle done pulse marks it as valid.

The controller has three states. ST_IDLE moves to ST_RUN on start, loading the word. ST_RUN stays put while the step counter is below six, and moves to ST_DONE on the seventh step. ST_DONE returns to ST_IDLE unconditionally.

Top module: `osml_cyclic_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy_o and done_o are 0 and word_o is 0.
- R2: A start_i seen in ST_IDLE copies word_i into the register. busy_o is 1 and word_o equals that word in the next cycle.
- R3: done_o is high for exactly one cycle. That cycle is the eighth cycle after the loading edge, which is the eighth consecutive cycle with busy_o high. busy_o falls in the following cycle.
- R4: A codeword is returned unchanged. Bit i of a word is position i+1. The codewords are the 8 words that have even parity over every cyclic rotation of the bit set {3,4,6}.
- R5: A codeword with any one bit inverted is returned as the original codeword.
- R6: In a step, the bit in position 7 (bit 6) is inverted when at least two of these sums are 1: bits{6,3,4}, bits{6,1,5} and bits{6,0,2}. A word holding only bit 6 therefore returns as all zeros.
- R7: A start_i that arrives while busy_o is high is ignored. The word being decoded and the done timing are not disturbed.
- R8: After done_o, word_o holds the decoded word until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request; accepted only when idle |
| word_i | input | 7 | Received word, sampled with an accepted start |
| busy_o | output | 1 | High from the load until the done cycle inclusive |
| done_o | output | 1 | One-cycle pulse: word_o holds the decoded word |
| word_o | output | 7 | Register contents; the decoded word from done onward |

## Verification
Every one of the eight codewords is sent clean, which shows that no sum votes falsely. Each codeword is also sent with each of the seven single-bit errors, which shows that the vote fires only when the faulty bit reaches the top position. A start pulse is injected mid-decode to tell a true ignore apart from a restart or a corrupted load. Random picks of codeword and error position are mixed with a lone top-bit error, which isolates the three-way vote.

// File: rtl/osml_pkg.sv
package osml_pkg;
    localparam int N     = 7;
    localparam int J     = 3;
    localparam int CNT_W = $clog2(N);
    localparam int SUM_W = $clog2(J + 1);
    localparam int VOTE_MIN = (J + 1) / 2;

    // Check j covers the top bit plus TAP_A[j] and TAP_B[j]
    localparam int TAP_A [J] = '{3, 1, 0};
    localparam int TAP_B [J] = '{4, 5, 2};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } osml_state_t;
endpackage

// File: rtl/osml_orth_vote.sv
module osml_orth_vote
    import osml_pkg::*;
(
    input  logic [N-1:0] word_i,
    output logic         flip_o
);
    logic [J-1:0]     sums;
    logic [SUM_W-1:0] ones;

    for (genvar j = 0; j < J; j++) begin : g_chk
        assign sums[j] = word_i[N-1] ^ word_i[TAP_A[j]] ^ word_i[TAP_B[j]];
    end

    always_comb begin
        ones = '0;
        for (int j = 0; j < J; j++) begin
            ones = ones + SUM_W'(sums[j]);
        end
        flip_o = (ones >= SUM_W'(VOTE_MIN));
    end
endmodule

// File: rtl/osml_ring_buf.sv
module osml_ring_buf
    import osml_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         flip_i,
    input  logic [N-1:0] word_i,
    output logic [N-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= word_i;
        end else if (step_i) begin
            q_o <= {q_o[N-2:0], q_o[N-1] ^ flip_i};
        end
    end
endmodule

// File: rtl/osml_seq_ctrl.sv
module osml_seq_ctrl
    import osml_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    osml_state_t      state_q, state_d;
    logic [CNT_W-1:0] step_cnt;
    logic             last_step;

    assign last_step = (step_cnt == CNT_W'(N - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt <= '0;
        end else if (load_o) begin
            step_cnt <= '0;
        end else if (step_o) begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_RUN;
            ST_RUN:  if (last_step) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_DONE: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/osml_cyclic_decoder.sv
module osml_cyclic_decoder
    import osml_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [N-1:0] word_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [N-1:0] word_o
);
    logic load, step, flip;

    osml_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    osml_orth_vote u_vote (
        .word_i (word_o),
        .flip_o (flip)
    );

    osml_ring_buf u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .flip_i (flip),
        .word_i (word_i),
        .q_o    (word_o)
    );
endmodule

// File: rtl/osml_cyclic_decoder_chk.sv
module osml_cyclic_decoder_chk
    import osml_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [N-1:0] word_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [N-1:0] word_o
);
    logic [CNT_W:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_cnt <= '0;
        else if (!busy_o) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 1'b1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_DONE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R3
    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (done_o == (busy_cnt == (CNT_W+1)'(N)))); // R7
    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && word_o == $past(word_i))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(word_o)); // R8
    AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R3
endmodule

bind osml_cyclic_decoder osml_cyclic_decoder_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .word_i  (word_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .word_o  (word_o)
);

// File: tb/osml_cyclic_decoder_tb_top.sv
module osml_cyclic_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] word_i = '0;
    logic       busy_o, done_o;
    logic [6:0] word_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic [6:0] cw [8];

    always #2 clk = ~clk;

    osml_cyclic_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
        .busy_o(busy_o), .done_o(done_o), .word_o(word_o)
    );

    function automatic logic [6:0] rotl(logic [6:0] w, int s);
        logic [6:0] r = w;
        for (int i = 0; i < s; i++) r = {r[5:0], r[6]};
        return r;
    endfunction

    function automatic bit is_code(logic [6:0] w);
        for (int s = 0; s < 7; s++) begin
            if (^(w & rotl(7'b1011000, s))) return 0;
        end
        return 1;
    endfunction

    task automatic check(string req, logic [6:0] act, logic [6:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Decode one word; optionally inject a start mid-run (R7)
    task automatic run_word(string req, logic [6:0] in, logic [6:0] exp, bit poke);
        @(negedge clk);
        start_i = 1'b1;
        word_i  = in;
        @(negedge clk);
        start_i = 1'b0;
        word_i  = ~in;
        check("R2 busy", {6'b0, busy_o}, 7'd1);
        for (int i = 0; i < 7; i++) begin
            if (poke && i == 2) start_i = 1'b1;
            if (poke && i == 3) start_i = 1'b0;
            @(negedge clk);
            if (i < 6 && done_o !== 1'b0) check("R3 early done", {6'b0, done_o}, 7'd0);
        end
        check("R3 done", {6'b0, done_o}, 7'd1);
        check(req, word_o, exp);
        @(negedge clk);
        check("R3 busy fall", {5'b0, busy_o, done_o}, 7'd0);
        @(negedge clk);
        check("R8 hold", word_o, exp);
    endtask

    initial begin
        int k;
        void'($urandom(32'h5EED1234));
        k = 0;
        for (int w = 0; w < 128; w++) begin
            if (is_code(7'(w)) && k < 8) begin
                cw[k] = 7'(w);
                k++;
            end
        end
        check("R4 codeword count", 7'(k), 7'd8);
        #1;
        check("R1 reset", {busy_o, done_o, word_o[4:0]}, 7'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {busy_o, done_o, word_o[4:0]}, 7'd0);
        check("R1 word", word_o, 7'd0);

        run_word("R6 lone top bit", 7'b1000000, 7'b0000000, 0);
        for (int c = 0; c < 8; c++) begin
            run_word("R4 clean", cw[c], cw[c], 0);
            for (int p = 0; p < 7; p++) begin
                run_word("R5 single error", cw[c] ^ (7'd1 << p), cw[c], 0);
            end
        end
        run_word("R7 start while busy", cw[3] ^ 7'b0000100, cw[3], 1);
        run_word("R7 start while busy", cw[5] ^ 7'b1000000, cw[5], 1);
        for (int n = 0; n < 40; n++) begin
            int c = $urandom % 8;
            int p = $urandom % 8;
            logic [6:0] e = (p == 7) ? 7'd0 : (7'd1 << p);
            run_word(p == 7 ? "R4 random clean" : "R5 random error",
                     cw[c] ^ e, cw[c], ($urandom % 4) == 0);
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule